// File: doc/BRIEF.md
# Cascaded Boxcar Decimation-Free Bitstream Filter

This block smooths the output of a sigma-delta modulator at the full modulator rate. On every clock where a new modulator sample is offered, the sample is converted to a signed value and passed through a chain of equal-length moving-sum (boxcar) stages. The sum held by each stage is exposed as a tap. Control loops can therefore read a fast, coarse early stage and the slow, fine last stage in the same cycle. The last stage is the filter result.

A parameter chooses the input variant at elaboration. In single-bit mode, a one counts as +1 and a zero counts as -1. In multi-bit mode, the input is a signed two's-complement code of `CODE_W` bits. Each stage is a running sum over a circular delay line. Every stage widens its sum by ceil(log2 `STAGE_LEN`) bits, so the sums can never wrap. A single input qualifier advances every stage together. A settled flag shows when enough samples have passed for the last stage to depend only on real input.

Top module: `sdf_boxcar_filter`

## Requirements
- R1: With `CODE_W` = 1, input bit 1 enters the chain as +1 and bit 0 as -1. With `CODE_W` > 1, the input bits are a signed two's-complement value (for example 5'b10110 is -10).
- R2: After each accepted sample, tap 0 equals the sum of the last `STAGE_LEN` mapped samples accepted since reset. Samples not yet received count as zero.
- R3: After each accepted sample, tap k (k >= 1) equals the sum of the values tap k-1 held just before each of the last `STAGE_LEN` accepted samples. This is a lag of one sample per stage.
- R4: `out_o` always equals the last tap, `tap_o[NUM_STAGES-1]`.
- R5: In a cycle where `in_valid_i` is low, no tap, `out_o` or `settled_o` changes.
- R6: `settled_o` is low until the `NUM_STAGES*STAGE_LEN`-th accepted sample after reset. It goes high with that sample's update and stays high until reset.
- R7: When a constant mapped value x has been accepted for at least `NUM_STAGES*STAGE_LEN` samples, `out_o` equals x times `STAGE_LEN` raised to the power `NUM_STAGES`.
- R8: No stage wraps. At the most negative multi-bit code held long enough, `out_o` reaches -2^(CODE_W-1) times `STAGE_LEN`^`NUM_STAGES` exactly.
- R9: An active-low reset clears all taps, the output, `out_valid_o`, `settled_o` and all delay-line contents.
- R10: `out_valid_o` is high for exactly the cycle after each cycle with `in_valid_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | A new modulator sample is present |
| in_code_i | input | CODE_W | Modulator bit or signed code |
| out_valid_o | output | 1 | Taps and output were just updated |
| out_o | output | FW | Last-stage sum, signed |
| tap_o | output | NUM_STAGES x FW | Every stage sum, sign-extended to FW, stage 0 in index 0 |
| settled_o | output | 1 | Last stage now depends only on real input |

## Verification
The hardest case to reach is a full, exact last-stage sum at the edge of the signed range. Every stage's delay line has to be filled with the extreme value, and the accepted samples have to be counted across stalls. The stimulus holds the most negative code and a constant one for more than `NUM_STAGES*STAGE_LEN` accepted samples, then checks the exact power-of-length product. Random stalls are mixed into the random phases so that the lag between stages is checked when valid samples are not back to back. A reset in the middle of the run, followed by fresh samples, shows through later sums that the delay lines were really cleared.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
   // width of one mapped sample entering the first stage
   function automatic int sample_w(input int code_w);
      return (code_w == 1) ? 2 : code_w;
   endfunction

   // bits added by one boxcar of the given length
   function automatic int grow_w(input int len);
      return $clog2(len);
   endfunction
endpackage

// File: rtl/sdf_input_map.sv
module sdf_input_map #(
   parameter int CODE_W = 1,
   parameter int SW     = 2
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [SW-1:0]     samp_o
);
   generate
      if (CODE_W == 1) begin : g_bit
         // single bit: one -> +1, zero -> -1
         assign samp_o = code_i[0] ? SW'(1) : {SW{1'b1}};
      end else begin : g_code
         assign samp_o = code_i;
      end
   endgenerate
endmodule

// File: rtl/sdf_boxcar_stage.sv
module sdf_boxcar_stage #(
   parameter int IN_W  = 2,
   parameter int LEN   = 50,
   parameter int OUT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [IN_W-1:0]  din_i,
   output logic [OUT_W-1:0] sum_o
);
   localparam int PW = (LEN > 1) ? $clog2(LEN) : 1;
   localparam longint BND = longint'(LEN) << (IN_W - 1);

   logic [IN_W-1:0]  line_q [LEN];
   logic [PW-1:0]    ptr_q;
   logic [OUT_W-1:0] sum_q;
   logic [IN_W-1:0]  oldest;
   logic signed [OUT_W-1:0] din_x, old_x;

   assign oldest = line_q[ptr_q];
   assign din_x  = OUT_W'($signed(din_i));
   assign old_x  = OUT_W'($signed(oldest));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < LEN; j++) line_q[j] <= '0;
         ptr_q <= '0;
         sum_q <= '0;
      end else if (en_i) begin
         line_q[ptr_q] <= din_i;
         ptr_q <= (ptr_q == PW'(LEN - 1)) ? '0 : ptr_q + PW'(1);
         sum_q <= sum_q + din_x - old_x;
      end
   end

   assign sum_o = sum_q;

   // R5: a stall leaves the stage sum untouched
   p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(sum_q));
   // R8: the sum never exceeds LEN times the largest input magnitude
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (longint'($signed(sum_q)) <= BND) && (longint'($signed(sum_q)) >= -BND));
endmodule

// File: rtl/sdf_settle_ctr.sv
module sdf_settle_ctr #(
   parameter int TARGET = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic settled_o
);
   localparam int CW = $clog2(TARGET + 1);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cnt_q <= '0;
      else if (en_i && cnt_q != CW'(TARGET))  cnt_q <= cnt_q + CW'(1);
   end

   assign settled_o = (cnt_q == CW'(TARGET));

   // R6: once settled, stays settled
   p_settle_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      settled_o |=> settled_o);
   // R6: settling happens only on an accepted sample
   p_settle_on_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(settled_o) |-> $past(en_i));
endmodule

// File: rtl/sdf_boxcar_filter.sv
module sdf_boxcar_filter #(
   parameter int CODE_W     = 1,
   parameter int STAGE_LEN  = 50,
   parameter int NUM_STAGES = 4,
   localparam int SW = sdf_pkg::sample_w(CODE_W),
   localparam int LG = sdf_pkg::grow_w(STAGE_LEN),
   localparam int FW = SW + NUM_STAGES * LG
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               in_valid_i,
   input  logic [CODE_W-1:0]                  in_code_i,
   output logic                               out_valid_o,
   output logic [FW-1:0]                      out_o,
   output logic [NUM_STAGES-1:0][FW-1:0]      tap_o,
   output logic                               settled_o
);
   localparam longint STEP = longint'(1) << SW;

   generate
      if (STAGE_LEN < 2) begin : g_bad_len
         $error("STAGE_LEN must be at least 2");
      end
      if (NUM_STAGES < 1) begin : g_bad_stages
         $error("NUM_STAGES must be at least 1");
      end
      if (CODE_W < 1 || CODE_W > 16) begin : g_bad_code
         $error("CODE_W must lie in 1..16");
      end
   endgenerate

   logic [SW-1:0] samp;

   sdf_input_map #(.CODE_W(CODE_W), .SW(SW)) u_map (
      .code_i (in_code_i),
      .samp_o (samp)
   );

   generate
      for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
         localparam int IW = SW + i * LG;
         localparam int OW = IW + LG;
         logic [IW-1:0] din;
         logic [OW-1:0] sum;
         if (i == 0) begin : g_first
            assign din = samp;
         end else begin : g_chain
            assign din = tap_o[i-1][IW-1:0];
         end
         sdf_boxcar_stage #(.IN_W(IW), .LEN(STAGE_LEN), .OUT_W(OW)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (in_valid_i),
            .din_i (din),
            .sum_o (sum)
         );
         assign tap_o[i] = FW'($signed(sum));
      end
   endgenerate

   assign out_o = tap_o[NUM_STAGES-1];

   sdf_settle_ctr #(.TARGET(NUM_STAGES * STAGE_LEN)) u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (in_valid_i),
      .settled_o (settled_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid_o <= 1'b0;
      else        out_valid_o <= in_valid_i;
   end

   // R5: output and flag frozen across a stall
   p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid_i |=> $stable(out_o) && $stable(settled_o));
   // R2: one sample moves the first sum by at most two sample magnitudes
   p_tap1_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i |=>
         ((longint'($signed(tap_o[0])) - longint'($signed($past(tap_o[0])))) <= STEP) &&
         ((longint'($signed(tap_o[0])) - longint'($signed($past(tap_o[0])))) >= -STEP));
endmodule

// File: tb/sim_sdf_boxcar_filter.sv
`timescale 1ns/1ps
module sim_sdf_boxcar_filter;
   localparam int L   = 50;
   localparam int NS  = 4;
   localparam int FW0 = 26;   // 2 + 4*6
   localparam int FW1 = 29;   // 5 + 4*6

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_v = 1'b0;
   logic code0 = 1'b0;
   logic [4:0] code1 = '0;

   logic                     u0_ov, u1_ov, u0_st, u1_st;
   logic [FW0-1:0]           u0_out;
   logic [FW1-1:0]           u1_out;
   logic [NS-1:0][FW0-1:0]   u0_tap;
   logic [NS-1:0][FW1-1:0]   u1_tap;

   always #2.5 clk = ~clk;

   sdf_boxcar_filter #(.CODE_W(1), .STAGE_LEN(L), .NUM_STAGES(NS)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid_i(in_v), .in_code_i(code0),
      .out_valid_o(u0_ov), .out_o(u0_out), .tap_o(u0_tap), .settled_o(u0_st));

   sdf_boxcar_filter #(.CODE_W(5), .STAGE_LEN(L), .NUM_STAGES(NS)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid_i(in_v), .in_code_i(code1),
      .out_valid_o(u1_ov), .out_o(u1_out), .tap_o(u1_tap), .settled_o(u1_st));

   // behavioural reference: per design, per stage, the last L stage inputs
   longint hist [2][NS][L];
   longint st   [2][NS];
   int     wp   [2];
   int     cnt  [2];
   bit     expv;
   bit     last_stall;
   int     n_cmp = 0;
   int     n_bad = 0;
   bit     done = 1'b0;

   task automatic model_clear();
      for (int d = 0; d < 2; d++) begin
         for (int k = 0; k < NS; k++) begin
            st[d][k] = 0;
            for (int j = 0; j < L; j++) hist[d][k][j] = 0;
         end
         wp[d] = 0;
         cnt[d] = 0;
      end
      expv = 1'b0;
      last_stall = 1'b0;
   endtask

   task automatic model_step(input int d, input longint x);
      longint inp [NS];
      for (int k = 0; k < NS; k++) inp[k] = (k == 0) ? x : st[d][k-1];
      for (int k = 0; k < NS; k++) hist[d][k][wp[d]] = inp[k];
      wp[d] = (wp[d] + 1) % L;
      for (int k = 0; k < NS; k++) begin
         longint s = 0;
         for (int j = 0; j < L; j++) s += hist[d][k][j];
         st[d][k] = s;
      end
      cnt[d]++;
   endtask

   task automatic chk(input string tag, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      string ts;
      for (int k = 0; k < NS; k++) begin
         ts = last_stall ? "R5" : ((k == 0) ? "R2" : "R3");
         chk(ts, longint'($signed(u0_tap[k])), st[0][k]);
         chk(ts, longint'($signed(u1_tap[k])), st[1][k]);
      end
      chk("R4", longint'($signed(u0_out)), st[0][NS-1]);
      chk("R4", longint'($signed(u1_out)), st[1][NS-1]);
      chk("R6", longint'(u0_st), longint'(cnt[0] >= NS * L));
      chk("R6", longint'(u1_st), longint'(cnt[1] >= NS * L));
      chk("R10", longint'(u0_ov), longint'(expv));
      chk("R10", longint'(u1_ov), longint'(expv));
   endtask

   // one cycle: check the state left by the last edge, then drive the next sample
   task automatic step(input bit v, input bit b0, input logic [4:0] b1);
      @(negedge clk);
      compare_all();
      in_v = v; code0 = b0; code1 = b1;
      if (v) begin
         model_step(0, b0 ? 64'sd1 : -64'sd1);   // R1 mapping of the bit
         model_step(1, longint'($signed(b1)));
      end
      last_stall = !v;
      expv = v;
   endtask

   task automatic reset_checks();
      for (int k = 0; k < NS; k++) begin
         chk("R9", longint'($signed(u0_tap[k])), 0);
         chk("R9", longint'($signed(u1_tap[k])), 0);
      end
      chk("R9", longint'(u0_st), 0);
      chk("R9", longint'(u1_ov), 0);
      chk("R9", longint'($signed(u1_out)), 0);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         finish_run();
      end
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      reset_checks();
      rst_n = 1'b1;

      // R1: first samples after reset show the mapping directly in tap 0
      step(1'b1, 1'b0, 5'b10110);
      step(1'b0, 1'b0, 5'b00000);
      chk("R1", longint'($signed(u0_tap[0])), -1);
      chk("R1", longint'($signed(u1_tap[0])), -10);

      // random bitstream and codes with stalls
      for (int i = 0; i < 600; i++)
         step(($urandom % 10) < 7, 1'($urandom), 5'($urandom));

      // R7 / R8: constant extremes held past full settling, with stalls
      for (int i = 0; i < 260; i++)
         step((i % 5) != 3, 1'b1, 5'b10000);
      step(1'b0, 1'b1, 5'b10000);
      chk("R7", longint'($signed(u0_out)), 64'sd6250000);
      chk("R8", longint'($signed(u1_out)), -64'sd100000000);
      chk("R6", longint'(u0_st), 1);

      // R9: reset in mid-run, then fresh data must see empty delay lines
      @(negedge clk);
      rst_n = 1'b0;
      in_v = 1'b0;
      model_clear();
      @(negedge clk);
      reset_checks();
      rst_n = 1'b1;
      for (int i = 0; i < 320; i++)
         step(($urandom % 4) != 0, 1'(i % 3 == 0), 5'($urandom));
      step(1'b0, 1'b0, 5'b00000);

      done = 1'b1;
      finish_run();
   end
endmodule